// File: doc/BRIEF.md
# Seeded Additive Scrambler for 130-Bit Coded Blocks

This block scrambles the 128-bit payload of a coded block whose 2-bit header travels beside it unscrambled. The keystream comes from a free-running 23-bit linear feedback shift register with polynomial x^23 + x^21 + x^16 + x^8 + x^5 + x^2 + 1. The keystream depends only on the register and never on the data. Because of this, the same instance scrambles at the transmitter and descrambles at the receiver. Because of this, it also cannot recover step by itself: both ends must be loaded with the same seed through an explicit seed strobe.

Each accepted block moves the register forward by 128 steps within a single cycle. The coded result appears one clock later as a 130-bit word. An idle cycle leaves the register untouched, so gaps between blocks do not shift the keystream. The logic that decides when to resynchronise sits outside this block.

Top module: `scr130_top`

## Requirements
- R1: After reset, validOut is 0 and dataOut is all zeros. The register holds SEED_INIT, which is all ones (23'h7FFFFF) by default, and the first block after reset is scrambled from that state.
- R2: validOut is 1 in the cycle after a cycle with validIn high, and 0 in the cycle after a cycle with validIn low.
- R3: The output word places the header unchanged in dataOut[129:128] and the processed payload in dataOut[127:0], belonging to the same input block.
- R4: Payload bit i (i = 0 is the LSB) is XORed with keystream bit i. Keystream bit i is state bit 22 taken before the i-th step. One step shifts the state left by one, fills bit 0 with 0, and, when the old bit 22 was 1, XORs in the tap mask 23'h210125 (bits 21, 16, 8, 5, 2, 0).
- R5: Each accepted block advances the state by exactly 128 steps, so back-to-back blocks use consecutive keystream segments.
- R6: In a cycle with validIn low and seedLoad low the state does not change, so an idle gap does not alter the keystream of the next block.
- R7: seedLoad high in a cycle without validIn loads seedIn into the state, and the next block is scrambled from that seed.
- R8: When seedLoad and validIn are high in the same cycle, the block in that cycle is scrambled from the new seed.
- R9: Applying the block twice, from the same seed, returns the original payload.
- R10: A seed of zero yields an all-zero keystream, so the payload passes unchanged.
- R11: dataOut holds its value in cycles following a cycle with validIn low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | A block is presented this cycle |
| hdrIn | input | 2 | Block header, passed through |
| payloadIn | input | 128 | Payload to scramble or descramble |
| seedLoad | input | 1 | Load seedIn into the register |
| seedIn | input | 23 | Seed value |
| validOut | output | 1 | dataOut carries a new block |
| dataOut | output | 130 | {header, processed payload} |

## Verification
The bench builds the block with its default parameters: a 128-bit payload, a 2-bit header, a 23-bit register with the stated taps, and the all-ones reset seed. With these values, a bit-serial reference model in the bench can predict every keystream bit. The bench then compares whole 130-bit words across back-to-back blocks, idle gaps, seed loads alone and together with a block, the zero-seed lockup and a round trip.

// File: rtl/scr130_pkg.sv
package scr130_pkg;
  typedef struct packed {
    logic takeSeed;  // use seedIn instead of held state this cycle
    logic advance;   // a block is consumed, step state by payload width
    logic capture;   // register the coded word
  } scrStrobes_t;
endpackage

// File: rtl/scr130_ctrl.sv
module scr130_ctrl
  import scr130_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic        seedLoad,
  output scrStrobes_t strb,
  output logic        validOut
);
  always_comb begin
    strb.takeSeed = seedLoad;
    strb.advance  = validIn;
    strb.capture  = validIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  assert_idle_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);
endmodule

// File: rtl/scr130_datapath.sv
module scr130_datapath
  import scr130_pkg::*;
#(
  parameter int PAY_W = 128,
  parameter int HDR_W = 2,
  parameter int ST_W  = 23,
  parameter logic [ST_W-1:0] TAP_MASK  = 23'h210125,
  parameter logic [ST_W-1:0] SEED_INIT = 23'h7FFFFF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  scrStrobes_t            strb,
  input  logic [HDR_W-1:0]       hdrIn,
  input  logic [PAY_W-1:0]       payloadIn,
  input  logic [ST_W-1:0]        seedIn,
  output logic [PAY_W+HDR_W-1:0] dataOut
);
  localparam int OUT_W = PAY_W + HDR_W;

  logic [ST_W-1:0]  stateQ;
  logic [ST_W-1:0]  curState;
  logic [ST_W-1:0]  walk;
  logic [ST_W-1:0]  stateNext;
  logic [PAY_W-1:0] keyStream;

  // Unrolled Galois stepping: one keystream bit per step, LSB first.
  always_comb begin
    curState = strb.takeSeed ? seedIn : stateQ;
    walk     = curState;
    for (int i = 0; i < PAY_W; i++) begin
      keyStream[i] = walk[ST_W-1];
      walk = {walk[ST_W-2:0], 1'b0} ^ (walk[ST_W-1] ? TAP_MASK : '0);
    end
    stateNext = strb.advance ? walk : curState;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= SEED_INIT;
      dataOut <= '0;
    end else begin
      stateQ <= stateNext;
      if (strb.capture) dataOut <= {hdrIn, payloadIn ^ keyStream};
    end
  end

  assert_hdr_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> dataOut[OUT_W-1 -: HDR_W] == $past(hdrIn));
  assert_state_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.takeSeed) |=> $stable(stateQ));
  assert_seed_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeSeed && !strb.advance) |=> stateQ == $past(seedIn));
  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(dataOut));
endmodule

// File: rtl/scr130_top.sv
module scr130_top
  import scr130_pkg::*;
#(
  parameter int PAY_W = 128,
  parameter int HDR_W = 2,
  parameter int ST_W  = 23,
  parameter logic [ST_W-1:0] TAP_MASK  = 23'h210125,
  parameter logic [ST_W-1:0] SEED_INIT = 23'h7FFFFF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   validIn,
  input  logic [HDR_W-1:0]       hdrIn,
  input  logic [PAY_W-1:0]       payloadIn,
  input  logic                   seedLoad,
  input  logic [ST_W-1:0]        seedIn,
  output logic                   validOut,
  output logic [PAY_W+HDR_W-1:0] dataOut
);
  scrStrobes_t strb;

  scr130_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .seedLoad(seedLoad),
    .strb(strb), .validOut(validOut)
  );

  scr130_datapath #(
    .PAY_W(PAY_W), .HDR_W(HDR_W), .ST_W(ST_W),
    .TAP_MASK(TAP_MASK), .SEED_INIT(SEED_INIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .hdrIn(hdrIn),
    .payloadIn(payloadIn), .seedIn(seedIn), .dataOut(dataOut)
  );
endmodule

// File: tb/sim_scr130_top.sv
module sim_scr130_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         validIn = 1'b0;
  logic [1:0]   hdrIn = '0;
  logic [127:0] payloadIn = '0;
  logic         seedLoad = 1'b0;
  logic [22:0]  seedIn = '0;
  logic         validOut;
  logic [129:0] dataOut;

  int errors = 0;
  int checks = 0;
  logic [22:0] model = 23'h7FFFFF;

  always #5 clk = ~clk;

  scr130_top u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .hdrIn(hdrIn),
    .payloadIn(payloadIn), .seedLoad(seedLoad), .seedIn(seedIn),
    .validOut(validOut), .dataOut(dataOut)
  );

  // Reference keystream built from the R4 description; advances model.
  function automatic logic [127:0] nextKey();
    logic [127:0] k;
    for (int i = 0; i < 128; i++) begin
      k[i] = model[22];
      model = {model[21:0], 1'b0} ^ (model[22] ? 23'h210125 : 23'h0);
    end
    return k;
  endfunction

  task automatic check(string req, logic [129:0] act, logic [129:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one block (optionally with seed), sample one cycle later.
  task automatic sendBlock(logic [1:0] h, logic [127:0] p, logic ld,
                           logic [22:0] sd, string req, output logic [129:0] got);
    logic [127:0] k;
    @(negedge clk);
    validIn = 1'b1; hdrIn = h; payloadIn = p; seedLoad = ld; seedIn = sd;
    if (ld) model = sd;
    k = nextKey();
    @(negedge clk);
    validIn = 1'b0; seedLoad = 1'b0;
    got = dataOut;
    check({req, " valid"}, {129'b0, validOut}, 130'd1);
    check(req, dataOut, {h, p ^ k});
  endtask

  task automatic testReset();
    check("R1 validOut", {129'b0, validOut}, 130'd0);
    check("R1 dataOut", dataOut, 130'd0);
  endtask

  task automatic testFirstBlocks();
    logic [129:0] g;
    sendBlock(2'b01, 128'h0, 1'b0, '0, "R1 R4 first block", g);
    sendBlock(2'b10, 128'hDEADBEEF_01234567_89ABCDEF_FEDCBA98, 1'b0, '0, "R5 R3 second", g);
    sendBlock(2'b11, {128{1'b1}}, 1'b0, '0, "R5 third", g);
  endtask

  task automatic testGap();
    logic [129:0] g, held;
    sendBlock(2'b01, 128'h5555, 1'b0, '0, "R4 pre-gap", g);
    held = dataOut;
    repeat (3) @(negedge clk);
    check("R2 idle", {129'b0, validOut}, 130'd0);
    check("R11 hold", dataOut, held);
    sendBlock(2'b10, 128'hA5A5_0000_FFFF_1234, 1'b0, '0, "R6 after gap", g);
  endtask

  task automatic testSeedAlone();
    logic [129:0] g;
    @(negedge clk);
    seedLoad = 1'b1; seedIn = 23'h12345;
    @(negedge clk);
    seedLoad = 1'b0;
    model = 23'h12345;
    check("R2 seed only", {129'b0, validOut}, 130'd0);
    repeat (2) @(negedge clk);
    sendBlock(2'b01, 128'h0, 1'b0, '0, "R7 seeded", g);
  endtask

  task automatic testSeedWithBlock();
    logic [129:0] g;
    sendBlock(2'b10, 128'hCAFE, 1'b1, 23'h4ABCD, "R8 seed with block", g);
    sendBlock(2'b01, 128'h0, 1'b0, '0, "R8 R5 following", g);
  endtask

  task automatic testRoundTrip();
    logic [129:0] first, second;
    logic [127:0] orig = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    sendBlock(2'b01, orig, 1'b1, 23'h6B1F0, "R9 scramble", first);
    sendBlock(2'b01, first[127:0], 1'b1, 23'h6B1F0, "R9 descramble", second);
    check("R9 round trip", {2'b01, second[127:0]}, {2'b01, orig});
  endtask

  task automatic testZeroSeed();
    logic [129:0] g;
    sendBlock(2'b10, 128'h1234_5678, 1'b1, 23'h0, "R10 zero seed", g);
    check("R10 identity", g, {2'b10, 128'h1234_5678});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testFirstBlocks();
    testGap();
    testSeedAlone();
    testSeedWithBlock();
    testRoundTrip();
    testZeroSeed();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule